// File: doc/BRIEF.md
# Class-D Bridge Protection Supervisor

This block is the digital supervisor that sits between a PWM modulator and a two-channel bridge-tied-load class-D power stage. Each channel has four switches arranged as two half-bridges, a plus side and a minus side. The block turns the modulator's per-side PWM bits into high-side and low-side gate enables. It inserts a dead interval at every changeover and reports a high-impedance indication for each half-bridge. Gate drivers, bootstrap supplies, comparators and the regulator are outside it.

The block also gathers the power stage's protection events into one active-low fault line. These are a per-half-bridge over-current flag, which is answered by a timed lockout with automatic retry, and a two-level over-temperature detector whose release follows hysteresis. A sampled supply-voltage code drives an under-voltage gate that has separate enable and disable thresholds. A per-channel monitor latches that channel off when its two PWM inputs stay different for too long, because that leaves DC across the speaker. A standby input holds everything in its initial state, and a mute input floats every output without raising a fault. All timeouts are counted in clock cycles. The default thresholds assume a supply code of 1/16 V per LSB.

Top module: `cdsup_top`

## Requirements
- R1: While standby is low, every high-side and low-side enable is 0, every high-impedance indication is 1, the fault line reads 1, and latched offset faults are cleared. The same values hold while the asynchronous reset is low.
- R2: While mute is low, every half-bridge is high impedance with both enables 0, and the fault line is not pulled low by the mute.
- R3: Half-bridge index 0 follows the channel-1 plus input (pwm_p[0]), index 1 follows channel-1 minus (pwm_n[0]), index 2 follows channel-2 plus (pwm_p[1]) and index 3 follows channel-2 minus (pwm_n[1]). When the stage is enabled, an input of 1 selects the high side and an input of 0 selects the low side.
- R4: The two enables of one half-bridge are never 1 together. A changeover from one side to the other goes through exactly one cycle with both enables 0. The enable that turns off does so at the first clock edge after the PWM input changes.
- R5: An over-current flag that is still high after synchronisation turns off only its own half-bridge, from the third edge on, for OC_OFF_CYC+1 cycles. The stage is then re-enabled for one cycle, and if the flag is still high it locks out again.
- R6: A high over-temperature flag turns off every half-bridge. The outputs return only after both the over-temperature flag and the release flag are low.
- R7: The under-voltage gate disables every half-bridge while it is active. It becomes active when the supply code falls below UV_OFF_CODE, and it releases only when the code is above UV_ON_CODE. Codes in between keep the current state. The gate is active on leaving standby until a good code is seen.
- R8: When one channel's plus and minus inputs differ on OFS_CYC consecutive clock edges, that channel alone goes to high impedance at the next edge. A single edge on which they agree restarts the count.
- R9: An offset fault stays latched after the inputs agree again. It is cleared only by mute low or standby low.
- R10: While standby is high, the fault line goes low when any over-current lockout, thermal lock, under-voltage gate or offset latch is active. It returns to 1 when none is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby | input | 1 | Standby control, high for operation (asynchronous) |
| mute | input | 1 | Mute control, high for switching (asynchronous) |
| pwm_p | input | NCH | Plus-side PWM per channel, synchronous to clk |
| pwm_n | input | NCH | Minus-side PWM per channel, synchronous to clk |
| oc_flag | input | 2*NCH | Over-current flag per half-bridge (asynchronous) |
| ot_hot | input | 1 | Over-temperature trip flag (asynchronous) |
| ot_clr | input | 1 | Over-temperature not-yet-cool flag (asynchronous) |
| vsup_code | input | VW | Sampled supply-voltage code |
| hs_en | output | 2*NCH | High-side enable per half-bridge |
| ls_en | output | 2*NCH | Low-side enable per half-bridge |
| hiz | output | 2*NCH | Half-bridge disabled (high impedance) |
| fault_n | output | 1 | Active-low protection summary |

## Verification
The properties assume that the PWM bits are already synchronous to the supervisor clock. They also assume that the supply code is held steady for at least two cycles around each change, so that the two-stage capture never sees a torn value. The bench drives every input on the falling edge and changes the supply code only between long settle intervals. The properties relate the synchronised controls and the internal lockout, thermal, under-voltage and offset states to the registered enables one edge later. They do not depend on how fast the raw asynchronous flags toggle.

// File: rtl/cdsup_pkg.sv
package cdsup_pkg;

  // channel that owns a half-bridge index
  function automatic int unsigned hb_chan(input int unsigned k);
    return k / 2;
  endfunction

  // 1 when a half-bridge index is the minus side
  function automatic bit hb_minus(input int unsigned k);
    return (k % 2) == 1;
  endfunction

  // under-voltage gate with hysteresis: activate below off_code, release above on_code
  function automatic logic uv_next(input logic uv_now, input int unsigned code,
                                   input int unsigned on_code, input int unsigned off_code);
    if (uv_now) return (code <= on_code);
    else        return (code < off_code);
  endfunction

endpackage

// File: rtl/cdsup_sync.sv
module cdsup_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= d;
      hold_q <= meta_q;
    end
  end

  assign q = hold_q;
endmodule

// File: rtl/cdsup_oc_guard.sv
module cdsup_oc_guard #(
  parameter int unsigned OFF_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic oc_s,
  output logic block
);
  localparam int CW = $clog2(OFF_CYC + 1);

  logic [CW-1:0] timer_q;
  logic          grace_q;
  logic          trip;

  // a retry cycle (grace) follows every expired lockout
  assign trip  = oc_s && (timer_q == '0) && !grace_q;
  assign block = trip || (timer_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer_q <= '0;
      grace_q <= 1'b0;
    end else if (clr) begin
      timer_q <= '0;
      grace_q <= 1'b0;
    end else begin
      grace_q <= (timer_q == CW'(1));
      if (trip)                 timer_q <= CW'(OFF_CYC);
      else if (timer_q != '0)   timer_q <= timer_q - 1'b1;
    end
  end
endmodule

// File: rtl/cdsup_offset_mon.sv
module cdsup_offset_mon #(
  parameter int unsigned LIMIT = 15_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic pos,
  input  logic neg,
  output logic fault
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] run_q;
  logic          fault_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      fault_q <= 1'b0;
    end else if (clr) begin
      run_q   <= '0;
      fault_q <= 1'b0;
    end else if (pos == neg) begin
      run_q <= '0;
    end else if (run_q == CW'(LIMIT - 1)) begin
      fault_q <= 1'b1;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign fault = fault_q;
endmodule

// File: rtl/cdsup_bridge_drv.sv
module cdsup_bridge_drv (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic pwm,
  output logic hs,
  output logic ls,
  output logic hiz
);
  logic hs_q, ls_q, hiz_q;
  logic want_hs, want_ls;

  assign want_hs = run && pwm;
  assign want_ls = run && !pwm;

  // a side turns on only once the opposite side has been off for a cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q  <= 1'b0;
      ls_q  <= 1'b0;
      hiz_q <= 1'b1;
    end else begin
      hs_q  <= want_hs && !ls_q;
      ls_q  <= want_ls && !hs_q;
      hiz_q <= !run;
    end
  end

  assign hs  = hs_q;
  assign ls  = ls_q;
  assign hiz = hiz_q;
endmodule

// File: rtl/cdsup_top.sv
module cdsup_top #(
  parameter int          NCH         = 2,
  parameter int          VW          = 8,
  parameter int unsigned OC_OFF_CYC  = 1000,
  parameter int unsigned OFS_CYC     = 15_000_000,
  parameter int unsigned UV_ON_CODE  = 112,
  parameter int unsigned UV_OFF_CODE = 96
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stby,
  input  logic             mute,
  input  logic [NCH-1:0]   pwm_p,
  input  logic [NCH-1:0]   pwm_n,
  input  logic [2*NCH-1:0] oc_flag,
  input  logic             ot_hot,
  input  logic             ot_clr,
  input  logic [VW-1:0]    vsup_code,
  output logic [2*NCH-1:0] hs_en,
  output logic [2*NCH-1:0] ls_en,
  output logic [2*NCH-1:0] hiz,
  output logic             fault_n
);
  import cdsup_pkg::*;

  localparam int NHB = 2 * NCH;

  // synchronised controls and flags
  logic [3:0]     ctl_s;
  logic           stby_s, mute_s, ot_hot_s, ot_clr_s;
  logic [NHB-1:0] oc_s;
  logic [VW-1:0]  vcode_s;

  cdsup_sync #(.W(4)) u_sync_ctl (
    .clk(clk), .rst_n(rst_n), .d({ot_clr, ot_hot, mute, stby}), .q(ctl_s)
  );
  cdsup_sync #(.W(NHB)) u_sync_oc (
    .clk(clk), .rst_n(rst_n), .d(oc_flag), .q(oc_s)
  );
  cdsup_sync #(.W(VW)) u_sync_vc (
    .clk(clk), .rst_n(rst_n), .d(vsup_code), .q(vcode_s)
  );

  assign stby_s   = ctl_s[0];
  assign mute_s   = ctl_s[1];
  assign ot_hot_s = ctl_s[2];
  assign ot_clr_s = ctl_s[3];

  // global protection states
  logic uv_q;
  logic ot_lock;
  logic fault_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       uv_q <= 1'b1;
    else if (!stby_s) uv_q <= 1'b1;
    else              uv_q <= uv_next(uv_q, int'(vcode_s), UV_ON_CODE, UV_OFF_CODE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ot_lock <= 1'b0;
    else if (!stby_s) ot_lock <= 1'b0;
    else              ot_lock <= ot_hot_s || (ot_lock && ot_clr_s);
  end

  // per-channel offset monitors
  logic [NCH-1:0] ofs_flt;
  logic           ofs_clr;

  assign ofs_clr = !stby_s || !mute_s;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    cdsup_offset_mon #(.LIMIT(OFS_CYC)) u_ofs (
      .clk(clk), .rst_n(rst_n), .clr(ofs_clr),
      .pos(pwm_p[c]), .neg(pwm_n[c]), .fault(ofs_flt[c])
    );
  end

  // per-half-bridge lockout and drive
  logic [NHB-1:0] oc_blk;
  logic [NHB-1:0] run;
  logic           gate_ok;

  assign gate_ok = stby_s && mute_s && !uv_q && !ot_lock;

  for (genvar k = 0; k < NHB; k++) begin : g_hb
    localparam int unsigned CH = hb_chan(k);
    localparam bit          MN = hb_minus(k);
    logic pwm_sel;

    assign pwm_sel = MN ? pwm_n[CH] : pwm_p[CH];
    assign run[k]  = gate_ok && !ofs_flt[CH] && !oc_blk[k];

    cdsup_oc_guard #(.OFF_CYC(OC_OFF_CYC)) u_oc (
      .clk(clk), .rst_n(rst_n), .clr(!stby_s), .oc_s(oc_s[k]), .block(oc_blk[k])
    );

    cdsup_bridge_drv u_drv (
      .clk(clk), .rst_n(rst_n), .run(run[k]), .pwm(pwm_sel),
      .hs(hs_en[k]), .ls(ls_en[k]), .hiz(hiz[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fault_q <= 1'b1;
    else if (!stby_s) fault_q <= 1'b1;
    else              fault_q <= !((|oc_blk) || ot_lock || uv_q || (|ofs_flt));
  end

  assign fault_n = fault_q;
endmodule

// File: rtl/cdsup_chk.sv
module cdsup_chk #(
  parameter int NCH = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2*NCH-1:0] hs_en,
  input logic [2*NCH-1:0] ls_en,
  input logic [2*NCH-1:0] hiz,
  input logic             fault_n,
  input logic             stby_s,
  input logic             mute_s,
  input logic             ot_lock,
  input logic             uv_q,
  input logic [NCH-1:0]   ofs_flt,
  input logic [2*NCH-1:0] oc_blk
);
  localparam int NHB = 2 * NCH;

  for (genvar k = 0; k < NHB; k++) begin : g_k
    localparam int CH = k / 2;

    p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_en[k] && ls_en[k]));

    p_dead_ls_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ls_en[k]) |-> !$past(hs_en[k]));

    p_dead_hs_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_en[k]) |-> !$past(ls_en[k]));

    p_mute_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !mute_s |=> (hiz[k] && !hs_en[k] && !ls_en[k]));

    p_oc_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      oc_blk[k] |=> (!hs_en[k] && !ls_en[k]));

    p_ofs_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ofs_flt[CH] |=> hiz[k]);
  end

  p_ot_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ot_lock |=> (hs_en == '0 && ls_en == '0));

  p_uv_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    uv_q |=> (hs_en == '0 && ls_en == '0));

  p_stby_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !stby_s |=> (fault_n && (&hiz)));

  p_fault_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_s && (ot_lock || uv_q || (|ofs_flt) || (|oc_blk))) |=> !fault_n);
endmodule

bind cdsup_top cdsup_chk #(.NCH(NCH)) i_chk (
  .clk(clk), .rst_n(rst_n), .hs_en(hs_en), .ls_en(ls_en), .hiz(hiz),
  .fault_n(fault_n), .stby_s(stby_s), .mute_s(mute_s), .ot_lock(ot_lock),
  .uv_q(uv_q), .ofs_flt(ofs_flt), .oc_blk(oc_blk)
);

// File: tb/test_cdsup_top.sv
module test_cdsup_top;
  localparam int NCH  = 2;
  localparam int NHB  = 4;
  localparam int VW   = 8;
  localparam int OCN  = 20;
  localparam int OFS  = 100;
  localparam int VON  = 112;
  localparam int VOFF = 96;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stby = 1'b0, mute = 1'b0, ot_hot = 1'b0, ot_clr = 1'b0;
  logic [NCH-1:0] pwm_p = '0, pwm_n = '0;
  logic [NHB-1:0] oc_flag = '0;
  logic [VW-1:0]  vsup_code = 8'd200;
  logic [NHB-1:0] hs_en, ls_en, hiz;
  logic           fault_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  cdsup_top #(
    .NCH(NCH), .VW(VW), .OC_OFF_CYC(OCN), .OFS_CYC(OFS),
    .UV_ON_CODE(VON), .UV_OFF_CODE(VOFF)
  ) i_cdsup_top (
    .clk(clk), .rst_n(rst_n), .stby(stby), .mute(mute),
    .pwm_p(pwm_p), .pwm_n(pwm_n), .oc_flag(oc_flag),
    .ot_hot(ot_hot), .ot_clr(ot_clr), .vsup_code(vsup_code),
    .hs_en(hs_en), .ls_en(ls_en), .hiz(hiz), .fault_n(fault_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {stby, mute, pwm_p[1:0], pwm_n[1:0], exp_hs, exp_ls, exp_hiz}
  localparam logic [17:0] VEC [0:7] = '{
    {1'b1, 1'b1, 2'b11, 2'b11, 4'b1111, 4'b0000, 4'b0000},
    {1'b1, 1'b1, 2'b00, 2'b00, 4'b0000, 4'b1111, 4'b0000},
    {1'b1, 1'b1, 2'b01, 2'b00, 4'b0001, 4'b1110, 4'b0000},
    {1'b1, 1'b1, 2'b00, 2'b10, 4'b1000, 4'b0111, 4'b0000},
    {1'b1, 1'b1, 2'b10, 2'b01, 4'b0110, 4'b1001, 4'b0000},
    {1'b1, 1'b0, 2'b11, 2'b11, 4'b0000, 4'b0000, 4'b1111},
    {1'b0, 1'b1, 2'b11, 2'b11, 4'b0000, 4'b0000, 4'b1111},
    {1'b1, 1'b1, 2'b11, 2'b00, 4'b0101, 4'b1010, 4'b0000}
  };

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    // reset state (R1)
    settle(3);
    check(hs_en == 0 && ls_en == 0, "R1 reset enables", {hs_en, ls_en}, 0);
    check(hiz == 4'hF, "R1 reset hiz", hiz, 4'hF);
    check(fault_n == 1'b1, "R1 reset fault_n", fault_n, 1);
    rst_n = 1'b1;
    stby = 1'b1; mute = 1'b1; pwm_p = 2'b11; pwm_n = 2'b11;
    settle(8);

    // table of steady patterns (R1, R2, R3)
    for (int v = 0; v < 8; v++) begin
      string tag;
      stby  = VEC[v][17];
      mute  = VEC[v][16];
      pwm_p = VEC[v][15:14];
      pwm_n = VEC[v][13:12];
      settle(8);
      tag = !VEC[v][17] ? "R1 vector" : (!VEC[v][16] ? "R2 vector" : "R3 vector");
      check(hs_en == VEC[v][11:8], tag, hs_en, VEC[v][11:8]);
      check(ls_en == VEC[v][7:4], tag, ls_en, VEC[v][7:4]);
      check(hiz == VEC[v][3:0], tag, hiz, VEC[v][3:0]);
      check(fault_n == 1'b1, tag, fault_n, 1);
    end

    // dead time on a changeover (R4)
    pwm_p = 2'b11; pwm_n = 2'b11;
    settle(4);
    pwm_p[0] = 1'b0;
    settle(1);
    check(hs_en[0] == 0 && ls_en[0] == 0, "R4 dead cycle hs->ls", {hs_en[0], ls_en[0]}, 0);
    settle(1);
    check(ls_en[0] == 1 && hs_en[0] == 0, "R4 low side on", {hs_en[0], ls_en[0]}, 1);
    pwm_p[0] = 1'b1;
    settle(1);
    check(hs_en[0] == 0 && ls_en[0] == 0, "R4 dead cycle ls->hs", {hs_en[0], ls_en[0]}, 0);
    settle(1);
    check(hs_en[0] == 1 && ls_en[0] == 0, "R4 high side on", {hs_en[0], ls_en[0]}, 2);

    // over-current lockout and retry on half-bridge 2 (R5)
    settle(2);
    oc_flag[2] = 1'b1;
    for (int i = 0; i <= OCN + 4; i++) begin
      bit exp_on;
      @(negedge clk);
      exp_on = (i < 2) || (i == OCN + 3);
      check(hs_en[2] == exp_on, "R5 lockout pattern", hs_en[2], exp_on);
      if (i == 5) begin
        check(hs_en[0] == 1'b1, "R5 other bridge unaffected", hs_en[0], 1);
        check(fault_n == 1'b0, "R10 fault on over-current", fault_n, 0);
      end
    end
    oc_flag[2] = 1'b0;
    settle(OCN + 8);
    check(hs_en[2] == 1'b1, "R5 recovery", hs_en[2], 1);
    check(fault_n == 1'b1, "R10 fault released", fault_n, 1);

    // thermal lock and two-flag release (R6)
    ot_hot = 1'b1;
    settle(6);
    check(hs_en == 0 && ls_en == 0 && hiz == 4'hF, "R6 thermal off", {hs_en, ls_en, hiz}, 4'hF);
    check(fault_n == 1'b0, "R10 fault on thermal", fault_n, 0);
    ot_hot = 1'b0; ot_clr = 1'b1;
    settle(6);
    check(hiz == 4'hF, "R6 held by release flag", hiz, 4'hF);
    ot_clr = 1'b0;
    settle(6);
    check(hiz == 4'h0 && hs_en == 4'hF, "R6 released", {hs_en, hiz}, 8'hF0);

    // under-voltage hysteresis (R7)
    vsup_code = 8'(VON);
    settle(6);
    check(hiz == 4'h0, "R7 at on-code stays on", hiz, 0);
    vsup_code = 8'd100;
    settle(6);
    check(hiz == 4'h0, "R7 mid band stays on", hiz, 0);
    vsup_code = 8'(VOFF - 1);
    settle(6);
    check(hiz == 4'hF && hs_en == 0, "R7 below off-code", {hs_en, hiz}, 4'hF);
    check(fault_n == 1'b0, "R10 fault on under-voltage", fault_n, 0);
    vsup_code = 8'd100;
    settle(6);
    check(hiz == 4'hF, "R7 mid band stays off", hiz, 4'hF);
    vsup_code = 8'(VON);
    settle(6);
    check(hiz == 4'hF, "R7 at on-code stays off", hiz, 4'hF);
    vsup_code = 8'(VON + 1);
    settle(6);
    check(hiz == 4'h0 && fault_n == 1'b1, "R7 above on-code", {fault_n, hiz}, 16);

    // offset detector on channel 1 with breaks (R8)
    pwm_p = 2'b11; pwm_n = 2'b10;
    settle(OFS - 5);
    pwm_n[0] = 1'b1;
    settle(1);
    pwm_n[0] = 1'b0;
    settle(OFS - 5);
    check(hiz[1:0] == 2'b00, "R8 break restarts count", hiz[1:0], 0);
    pwm_n[0] = 1'b1;
    settle(1);
    pwm_n[0] = 1'b0;
    settle(OFS);
    check(hiz[1:0] == 2'b00, "R8 one edge before trip", hiz[1:0], 0);
    settle(1);
    check(hiz[1:0] == 2'b11, "R8 channel tripped", hiz[1:0], 3);
    check(hiz[3:2] == 2'b00, "R8 other channel running", hiz[3:2], 0);
    check(fault_n == 1'b0, "R10 fault on offset", fault_n, 0);

    // latch held, cleared by mute and by standby (R9)
    pwm_n = 2'b11;
    settle(6);
    check(hiz[1:0] == 2'b11, "R9 latch holds", hiz[1:0], 3);
    mute = 1'b0;
    settle(5);
    mute = 1'b1;
    settle(8);
    check(hiz == 4'h0 && fault_n == 1'b1, "R9 cleared by mute", {fault_n, hiz}, 16);
    pwm_n = 2'b01;
    settle(OFS + 5);
    check(hiz[3:2] == 2'b11, "R8 channel 2 tripped", hiz[3:2], 3);
    pwm_n = 2'b11;
    stby = 1'b0;
    settle(5);
    check(fault_n == 1'b1 && hiz == 4'hF, "R1 standby idle", {fault_n, hiz}, 31);
    stby = 1'b1;
    settle(8);
    check(hiz == 4'h0 && fault_n == 1'b1, "R9 cleared by standby", {fault_n, hiz}, 16);

    finish_run();
  end
endmodule